// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Unit

This block is a byte-addressed arithmetic engine for a processor that has no hardware multiplier or divider of its own. Software first writes a control byte that picks the operation. It then writes two 16-bit operands one byte at a time. The operation fires when the most significant byte of the second operand is written. The result is a 40-bit word, read back one byte at a time with the least significant byte first. A status byte holds the accumulator overflow flag and a busy indication.

The block has three operations:
- A signed multiply, which finishes in the cycle of the launching write.
- A division of a signed dividend by an unsigned divisor. It runs on a sequential shift-subtract divider for one cycle per operand bit. The remainder is always non-negative and the quotient is adjusted to match it.
- A signed multiply-accumulate into the 40-bit result. It wraps modulo 2^40 and raises the overflow flag whenever the true sum falls outside the 40-bit unsigned range.

Top module: `mdac_unit`

## Requirements
- R1: After reset all five result bytes read 0x00 and the status byte reads 0x00 (overflow clear, idle).
- R2: A write to write address 0 stores the operation in bits 1:0: value 0 is signed multiply, 1 is division, and 2 or 3 is multiply-accumulate. Operand 1 occupies write addresses 1 (low byte) and 2 (high byte). Operand 2 occupies addresses 3 (low) and 4 (high).
- R3: A write to address 0 with bit 1 set clears the 40-bit result to zero. A write to address 0 with bit 1 clear leaves the result unchanged.
- R4: Only a write to address 4 launches an operation. Writes to addresses 0 to 3 never change the result, except for the clear described in R3.
- R5: Multiply places the signed 16x16 product, sign-extended to 40 bits, in the result in the cycle of the launching write. It then zeroes operand 2 and keeps operand 1.
- R6: Division treats operand 1 as signed and operand 2 as unsigned. It produces a remainder r with 0 <= r < divisor and the quotient (dividend - r) / divisor truncated to 16 bits. The result holds the quotient in bits 15:0, the remainder in bits 31:16 and zeros above. Both operands are zeroed afterwards.
- R7: Division by a zero divisor yields a result of 0.
- R8: A division keeps status bit 0 (busy) high for 16 cycles after the launching write. While busy, the result keeps its previous value and every register write is ignored.
- R9: Multiply-accumulate adds the sign-extended product to the result and keeps the low 40 bits. On every such operation it sets the overflow flag to 1 if the true sum is negative or at least 2^40, and to 0 otherwise. It then zeroes operand 2.
- R10: Multiply, division and control writes leave the overflow flag unchanged.
- R11: Read addresses 0 to 4 return result bits 7:0 up to 39:32 in that order. Read address 5 returns the status byte, with overflow in bit 7, busy in bit 0 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W (4) | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W (4) | Read register address |
| rd_data | output | 8 | Read data byte (combinational) |
| busy | output | 1 | High while a division is in progress |

## Verification
The bench builds the block with its default 16-bit operands and 40-bit result. At these widths, 1024 accumulations of the product 2^30 land exactly on the 2^40 wrap point, and a single accumulation of a negative product drives the sum below zero. Both overflow directions are therefore within a few thousand cycles. The 16-bit operand width also lets directed cases cover the dividend extremes 0x8000 and 0xFFFF against divisors of 1 and 0xFFFF. Random stimulus then mixes all modes and clears with a persistent accumulator.

// File: rtl/mdac_pkg.sv
package mdac_pkg;

  typedef enum logic [1:0] {
    OPC_MUL     = 2'd0,
    OPC_DIV     = 2'd1,
    OPC_ACC     = 2'd2,
    OPC_ACC_ALT = 2'd3
  } opc_e;

  // control byte bit that clears the result
  localparam int CTRL_CLR_BIT   = 1;
  // status byte bit positions
  localparam int STAT_OVF_BIT   = 7;
  localparam int STAT_BUSY_BIT  = 0;

endpackage

// File: rtl/mdac_operands.sv
module mdac_operands
  import mdac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output opc_e              opc,
  output logic [OP_W-1:0]   op1,
  output logic [OP_W-1:0]   op2_now,
  output logic              start,
  output logic              clr_res
);

  localparam int NB         = OP_W / 8;
  localparam int START_ADDR = 2 * NB;

  logic            take;
  opc_e            opc_q, opc_d;
  logic [OP_W-1:0] op1_q, op1_d;
  logic [OP_W-1:0] op2_q, op2_d;

  assign take    = wr_en && !busy;
  assign start   = take && (wr_addr == ADDR_W'(START_ADDR));
  assign clr_res = take && (wr_addr == '0) && wr_data[CTRL_CLR_BIT];

  // operand 2 as seen by the launching write: top byte replaced
  always_comb begin
    op2_now = op2_q;
    op2_now[OP_W-8 +: 8] = wr_data;
  end

  always_comb begin
    opc_d = opc_q;
    op1_d = op1_q;
    op2_d = op2_q;
    if (take) begin
      if (wr_addr == '0) opc_d = opc_e'(wr_data[1:0]);
      for (int i = 0; i < NB; i++) begin
        if (wr_addr == ADDR_W'(1 + i))      op1_d[8*i +: 8] = wr_data;
        if (wr_addr == ADDR_W'(1 + NB + i)) op2_d[8*i +: 8] = wr_data;
      end
      if (start) begin
        op2_d = '0;
        if (opc_q == OPC_DIV) op1_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= OPC_MUL;
      op1_q <= '0;
      op2_q <= '0;
    end else if (take) begin
      opc_q <= opc_d;
      op1_q <= op1_d;
      op2_q <= op2_d;
    end
  end

  assign opc = opc_q;
  assign op1 = op1_q;

endmodule

// File: rtl/mdac_divider.sv
module mdac_divider #(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   dividend,
  input  logic [OP_W-1:0]   divisor,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] result
);

  localparam int CNT_W = $clog2(OP_W + 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OP_W-1:0]  rem_q, rem_d;
  logic [OP_W-1:0]  quo_q, quo_d;
  logic [OP_W-1:0]  dvs_q, dvs_d;
  logic             neg_q, neg_d;

  logic [OP_W:0]    shifted;
  logic             ge;
  logic [OP_W-1:0]  rem_n;
  logic [OP_W-1:0]  quo_n;

  // one restoring shift-subtract step
  always_comb begin
    shifted = {rem_q, quo_q[OP_W-1]};
    ge      = shifted >= {1'b0, dvs_q};
    rem_n   = ge ? (shifted[OP_W-1:0] - dvs_q) : shifted[OP_W-1:0];
    quo_n   = {quo_q[OP_W-2:0], ge};
  end

  assign done = run_q && (cnt_q == CNT_W'(1));

  // sign fix-up: remainder forced into [0, divisor)
  always_comb begin
    if (dvs_q == '0) begin
      result = '0;
    end else if (!neg_q) begin
      result = {rem_n, quo_n};
    end else if (rem_n == '0) begin
      result = {{OP_W{1'b0}}, (~quo_n) + 1'b1};
    end else begin
      result = {dvs_q - rem_n, ~quo_n};
    end
  end

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    neg_d = neg_q;
    if (start && !run_q) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(OP_W);
      rem_d = '0;
      quo_d = dividend[OP_W-1] ? ((~dividend) + 1'b1) : dividend;
      dvs_d = divisor;
      neg_d = dividend[OP_W-1];
    end else if (run_q) begin
      rem_d = rem_n;
      quo_d = quo_n;
      cnt_d = cnt_q - 1'b1;
      if (done) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      neg_q <= 1'b0;
    end else if (run_q || start) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      neg_q <= neg_d;
    end
  end

  assign busy = run_q;

endmodule

// File: rtl/mdac_accum.sv
module mdac_accum
  import mdac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  opc_e              opc,
  input  logic [OP_W-1:0]   op1,
  input  logic [OP_W-1:0]   op2,
  input  logic              clr_res,
  input  logic              div_done,
  input  logic [2*OP_W-1:0] div_result,
  output logic [ACC_W-1:0]  res,
  output logic              ovf
);

  localparam int PW = 2 * OP_W;

  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_ext;
  logic [ACC_W+1:0]     sum_ext;
  logic [ACC_W-1:0]     res_q, res_d;
  logic                 ovf_q, ovf_d;
  logic                 res_en;

  assign prod     = $signed(op1) * $signed(op2);
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
  assign sum_ext  = {2'b00, res_q} + {{2{prod[PW-1]}}, prod_ext};

  always_comb begin
    res_d = res_q;
    ovf_d = ovf_q;
    if (clr_res) res_d = '0;
    if (start && (opc == OPC_MUL)) res_d = prod_ext;
    if (start && opc[1]) begin
      res_d = sum_ext[ACC_W-1:0];
      ovf_d = |sum_ext[ACC_W+1:ACC_W];
    end
    if (div_done) res_d = {{(ACC_W-PW){1'b0}}, div_result};
  end

  assign res_en = clr_res || start || div_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign res = res_q;
  assign ovf = ovf_q;

endmodule

// File: rtl/mdac_unit.sv
module mdac_unit
  import mdac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);

  localparam int RB = ACC_W / 8;

  logic              rst_sync1, rst_ns;
  opc_e              opc;
  logic [OP_W-1:0]   op1, op2_now;
  logic              start, clr_res;
  logic              div_busy, div_done;
  logic [2*OP_W-1:0] div_result;
  logic [ACC_W-1:0]  res;
  logic              ovf;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync1 <= 1'b0;
      rst_ns    <= 1'b0;
    end else begin
      rst_sync1 <= 1'b1;
      rst_ns    <= rst_sync1;
    end
  end

  mdac_operands #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_ops (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (div_busy),
    .opc     (opc),
    .op1     (op1),
    .op2_now (op2_now),
    .start   (start),
    .clr_res (clr_res)
  );

  mdac_divider #(.OP_W(OP_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_ns),
    .start    (start && (opc == OPC_DIV)),
    .dividend (op1),
    .divisor  (op2_now),
    .busy     (div_busy),
    .done     (div_done),
    .result   (div_result)
  );

  mdac_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_ns),
    .start      (start),
    .opc        (opc),
    .op1        (op1),
    .op2        (op2_now),
    .clr_res    (clr_res),
    .div_done   (div_done),
    .div_result (div_result),
    .res        (res),
    .ovf        (ovf)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < RB; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = res[8*i +: 8];
    end
    if (rd_addr == ADDR_W'(RB)) begin
      rd_data[STAT_OVF_BIT]  = ovf;
      rd_data[STAT_BUSY_BIT] = div_busy;
    end
  end

  assign busy = div_busy;

endmodule

// File: rtl/mdac_unit_chk.sv
module mdac_unit_chk
  import mdac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input opc_e              opc,
  input logic [ACC_W-1:0]  res,
  input logic              ovf
);

  localparam int NB         = OP_W / 8;
  localparam int START_ADDR = 2 * NB;
  localparam int LEN_W      = $clog2(OP_W + 1) + 1;

  logic             take;
  logic [LEN_W-1:0] run_len;

  assign take = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (busy)  run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < LEN_W'(OP_W)));

  // R8
  div_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_addr == ADDR_W'(START_ADDR) && opc == OPC_DIV) |=> busy);

  // R8
  stale_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(res));

  // R4
  no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_addr != '0 && wr_addr != ADDR_W'(START_ADDR)) |=> $stable(res));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_addr == '0 && wr_data[CTRL_CLR_BIT]) |=> (res == '0));

  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && wr_addr == ADDR_W'(START_ADDR) && opc[1]) |=> $stable(ovf));

endmodule

bind mdac_unit mdac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_ns),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (div_busy),
  .opc     (opc),
  .res     (res),
  .ovf     (ovf)
);

// File: tb/mdac_unit_test.sv
module mdac_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit skip_wait = 1'b0;

  logic [39:0] m_res = '0;
  logic        m_ovf = 1'b0;
  logic [1:0]  m_mode = 2'd0;
  logic [15:0] m_op1 = '0;
  logic [15:0] m_op2 = '0;

  always #10 clk = ~clk;

  mdac_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  function automatic longint sx(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  function automatic logic [39:0] f_mul(input logic [15:0] a, input logic [15:0] b);
    longint p = sx(a) * sx(b);
    return p[39:0];
  endfunction

  function automatic logic [39:0] f_div(input logic [15:0] a, input logic [15:0] b);
    longint da = sx(a);
    longint dv = {48'b0, b};
    longint r, q;
    if (b == 16'h0) return 40'h0;
    r = da % dv;
    if (r < 0) r = r + dv;
    q = (da - r) / dv;
    return {8'h00, r[15:0], q[15:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns 1 when a division was launched
  function automatic bit model_write(input logic [3:0] a, input logic [7:0] d);
    longint s;
    case (a)
      4'd0: begin m_mode = d[1:0]; if (d[1]) m_res = '0; end
      4'd1: m_op1[7:0]  = d;
      4'd2: m_op1[15:8] = d;
      4'd3: m_op2[7:0]  = d;
      4'd4: begin
        m_op2[15:8] = d;
        case (m_mode)
          2'd0: begin m_res = f_mul(m_op1, m_op2); m_op2 = '0; end
          2'd1: begin m_res = f_div(m_op1, m_op2); m_op1 = '0; m_op2 = '0; return 1'b1; end
          default: begin
            s = longint'({24'b0, m_res}) + sx(m_op1) * sx(m_op2);
            m_ovf = (s < 0) || (s > 64'sh00FF_FFFF_FFFF);
            m_res = s[39:0];
            m_op2 = '0;
          end
        endcase
      end
      default: ;
    endcase
    return 1'b0;
  endfunction

  task automatic drive(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic div_wait();
    int n = 0;
    check(busy === 1'b1, "R8 busy after launch", busy, 1);
    while (busy === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == 16, "R8 busy length", n, 16);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bit dv;
    drive(a, d);
    dv = model_write(a, d);
    if (dv && !skip_wait) div_wait();
  endtask

  task automatic read_all(output logic [39:0] r, output logic [7:0] st);
    for (int i = 0; i < 5; i++) begin
      rd_addr = 4'(i);
      #1;
      r[8*i +: 8] = rd_data;
    end
    rd_addr = 4'd5;
    #1;
    st = rd_data;
  endtask

  task automatic check_state(input string tag);
    logic [39:0] r;
    logic [7:0]  st;
    read_all(r, st);
    check(r === m_res, {tag, " R11 result"}, r, m_res);
    check(st === {m_ovf, 7'b0}, {tag, " R11 status"}, st, {m_ovf, 7'b0});
  endtask

  task automatic load_go(input logic [15:0] a, input logic [15:0] b);
    wr(4'd1, a[7:0]); wr(4'd2, a[15:8]);
    wr(4'd3, b[7:0]); wr(4'd4, b[15:8]);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 8)
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h0000;
      3: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [39:0] prev, r;
    logic [7:0]  st;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_state("R1 reset");

    // R2 R5 multiply
    wr(4'd0, 8'h00);
    load_go(16'hFFFD, 16'h0005);
    check_state("R5 mul -3*5");
    load_go(16'h8000, 16'h8000);
    check_state("R5 mul min*min");

    // R4 non-launching writes
    wr(4'd1, 8'h12); wr(4'd2, 8'h34); wr(4'd3, 8'h56);
    check_state("R4 no launch");

    // R5 operand 2 cleared, operand 1 kept
    wr(4'd4, 8'h01);
    check_state("R5 op2 cleared");

    // R3 clear and non-clear control writes
    wr(4'd0, 8'h01);
    check_state("R3 no clear");
    wr(4'd0, 8'h02);
    check_state("R3 clear");

    // R6 R7 division
    wr(4'd0, 8'h01);
    load_go(16'd7, 16'd2);       check_state("R6 7/2");
    load_go(16'hFFF9, 16'd2);    check_state("R6 -7/2");
    load_go(16'h8000, 16'd1);    check_state("R6 min/1");
    load_go(16'hFFFF, 16'hFFFF); check_state("R6 -1/max");
    load_go(16'h8000, 16'hFFFF); check_state("R6 min/max");
    load_go(16'd0, 16'd5);       check_state("R6 0/5");
    load_go(16'd100, 16'd0);     check_state("R7 zero divisor");

    // R6 operand 1 cleared by division
    load_go(16'd50, 16'd7);
    wr(4'd0, 8'h00);
    wr(4'd3, 8'h03); wr(4'd4, 8'h00);
    check_state("R6 op1 cleared");

    // R8 stale reads and ignored writes while busy
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h39); wr(4'd2, 8'hFC); wr(4'd3, 8'h0B);
    prev = m_res;
    skip_wait = 1'b1;
    wr(4'd4, 8'h00);
    skip_wait = 1'b0;
    read_all(r, st);
    check(r === prev, "R8 stale result", r, prev);
    check(st[0] === 1'b1, "R8 busy status", st, 8'h01);
    drive(4'd0, 8'h02);
    drive(4'd4, 8'h7F);
    drive(4'd1, 8'h55);
    while (busy === 1'b1) @(negedge clk);
    check_state("R8 writes ignored");
    wr(4'd0, 8'h00);
    wr(4'd3, 8'h01); wr(4'd4, 8'h00);
    check_state("R8 op1 untouched by ignored write");

    // R9 accumulate, negative and positive wrap
    wr(4'd0, 8'h03);
    load_go(16'h0001, 16'hFFFF); check_state("R9 below zero");
    wr(4'd3, 8'h01); wr(4'd4, 8'h00);
    check_state("R9 reach 2^40");
    wr(4'd3, 8'h01); wr(4'd4, 8'h00);
    check_state("R9 overflow recomputed");

    // R9 1024 accumulations of 2^30
    wr(4'd0, 8'h02);
    wr(4'd1, 8'h00); wr(4'd2, 8'h80);
    for (int i = 0; i < 1023; i++) begin
      wr(4'd3, 8'h00); wr(4'd4, 8'h80);
    end
    check_state("R9 just below wrap");
    wr(4'd3, 8'h00); wr(4'd4, 8'h80);
    check_state("R9 wrap to zero");

    // R10 overflow kept through multiply and division
    wr(4'd0, 8'h00);
    load_go(16'd3, 16'd4);
    check_state("R10 after mul");
    wr(4'd0, 8'h01);
    load_go(16'd9, 16'd4);
    check_state("R10 after div");

    // random mix
    for (int k = 0; k < 80; k++) begin
      int md = $urandom % 4;
      if (md != int'(m_mode) || ($urandom % 6) == 0)
        wr(4'd0, 8'(md));
      load_go(pick(), pick());
      check_state("R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule